// File: doc/BRIEF.md
# Coprocessor Bus Snooper and Escape Decoder

This block sits beside a host CPU and watches its bus. Every instruction byte the host fetches is copied into a local shadow of the host's prefetch queue. The host's queue-status lines say when a byte leaves that queue, and the block removes the same byte from its copy. Opcodes are taken only from the copy. A first byte whose top five bits mark an escape starts a coprocessor instruction, and the byte after it supplies the mode, the second part of the opcode and the register/memory field.

The host comes in two variants, and they have different queue sizes. In the first clock cycle after reset the block samples a strap line and sizes the shadow queue to match: four or six bytes. For a memory operand, the block snoops the host's own operand cycle.
- For a load, it captures the address and the first data word.
- For a store, it captures the address only.

If more words must move, the block raises a bus request and makes one transfer per granted cycle. It releases the request in the cycle right after the last transfer.

Top module: `cop_snoop`

## Requirements
- R1: In the first clock cycle after reset the block samples `host_sel_i`. A 1 gives a six-byte shadow queue and a 0 gives a four-byte one. A fetched byte that arrives while the queue holds that many bytes is dropped.
- R2: `qs_i` encoding: 2'b00 means no queue activity. 2'b01 removes the head byte as the first byte of an instruction. 2'b11 removes the head byte as a following byte. 2'b10 empties the queue and abandons a partly decoded instruction. A removal from an empty queue does nothing.
- R3: A first byte starts a coprocessor instruction only when its bits [7:3] equal 5'b11011. Any other first byte produces no decode.
- R4: One cycle after the following byte is removed, `dec_vld_o` is high for exactly one cycle, with these fields:
  - `dec_op_o` = {first[2:0], second[5:3]}
  - `dec_mod_o` = second[7:6]
  - `dec_rm_o` = second[2:0]
- R5: `dec_mem_o` is 0 only when the mode field is 2'b11. A register-form instruction causes no capture and no bus request.
- R6: The operand length in 16-bit words comes from first[2:1]: 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 5. Bit 4 of the second byte set marks a store. Cleared, it marks a load.
- R7: For a load, the first host memory cycle (`mem_vld_i`) after the decode latches the address into `op_addr_o` and the data into `op_data_o`. In the next cycle `op_rd_vld_o` pulses for one cycle.
- R8: For a store, that cycle latches only the address. `op_data_o` keeps its old value and `op_rd_vld_o` stays low.
- R9: When words remain, `bus_req_o` rises in the cycle after capture. `xfer_stb_o` pulses once per granted cycle at address base+2k, with `xfer_wr_o` equal to the store flag:
  - for a load, k runs from 1 to len-1;
  - for a store, k runs from 0 to len-1.
  `bus_req_o` is low in the cycle after the last strobe. A one-word load raises no request.
- R10: After reset all valid, request and strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host variant strap, sampled once after reset |
| fetch_vld_i | input | 1 | Host fetched an instruction byte |
| fetch_byte_i | input | 8 | Fetched instruction byte |
| qs_i | input | 2 | Host queue status |
| mem_vld_i | input | 1 | Host memory operand cycle |
| mem_addr_i | input | ADDR_W | Host operand address |
| mem_data_i | input | 16 | Host data bus |
| bus_gnt_i | input | 1 | Bus granted to this block |
| dec_vld_o | output | 1 | Decoded instruction pulse |
| dec_op_o | output | 6 | Six-bit opcode |
| dec_mod_o | output | 2 | Mode field |
| dec_rm_o | output | 3 | Register/memory field |
| dec_mem_o | output | 1 | Memory operand present |
| op_addr_o | output | ADDR_W | Latched operand address |
| op_data_o | output | 16 | Latched first read word |
| op_rd_vld_o | output | 1 | Read word captured pulse |
| bus_req_o | output | 1 | Bus request |
| xfer_stb_o | output | 1 | One operand word transferred |
| xfer_wr_o | output | 1 | Transfer is a write |
| xfer_addr_o | output | ADDR_W | Transfer word address |

## Verification
The queue is tested with the same byte stream under both strap values. Decoding happens only with the deeper queue, so a depth mistake shows up directly. Three other patterns separate the decode paths:
- a non-escape opcode;
- a flush between the escape byte and the following byte;
- a register-form escape.

Memory operands are tried as a one-word load, a two-word load and a five-word store. These cases tell apart the starting offset, the word count, the direction flag, the ignored store data and the release of the request.

// File: rtl/cop_snoop_pkg.sv
package cop_snoop_pkg;
  localparam logic [4:0] ESC_PATTERN = 5'b11011;

  typedef enum logic [1:0] {
    QS_NONE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  typedef enum logic [1:0] {
    X_IDLE,
    X_WAIT,
    X_BUS
  } xstate_e;

  function automatic logic [2:0] op_words(input logic [1:0] code);
    case (code)
      2'b00:   op_words = 3'd1;
      2'b01:   op_words = 3'd2;
      2'b10:   op_words = 3'd4;
      default: op_words = 3'd5;
    endcase
  endfunction
endpackage

// File: rtl/snoop_queue.sv
module snoop_queue #(
  parameter int MAX_DEPTH   = 6,
  parameter int SMALL_DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wide_i,
  input  logic       push_i,
  input  logic [7:0] push_byte_i,
  input  logic       pop_i,
  input  logic       flush_i,
  output logic [7:0] head_o,
  output logic       head_vld_o
);
  localparam int PW = $clog2(MAX_DEPTH);
  localparam int CW = $clog2(MAX_DEPTH + 1);

  logic [7:0]    mem_q [MAX_DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q, depth;
  logic          do_push, do_pop;

  assign depth      = wide_i ? CW'(MAX_DEPTH) : CW'(SMALL_DEPTH);
  assign head_o     = mem_q[rd_q];
  assign head_vld_o = (cnt_q != '0);
  assign do_push    = push_i && !flush_i && (cnt_q < depth);
  assign do_pop     = pop_i && !flush_i && head_vld_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    nxt = (p == PW'(MAX_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i) begin
      if (do_push && wr_q == PW'(i)) mem_q[i] <= push_byte_i;
    end
  end

  assert_fill_in_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= depth);
  assert_flush_empties_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !head_vld_o);
endmodule

// File: rtl/esc_decoder.sv
module esc_decoder
  import cop_snoop_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] qs_i,
  input  logic [7:0] head_i,
  input  logic       head_vld_i,
  output logic       pop_o,
  output logic       flush_o,
  output logic       dec_vld_o,
  output logic [5:0] dec_op_o,
  output logic [1:0] dec_mod_o,
  output logic [2:0] dec_rm_o,
  output logic       dec_mem_o,
  output logic [2:0] dec_words_o,
  output logic       dec_store_o
);
  logic       in_esc_q;
  logic [2:0] op_hi_q;
  logic [1:0] len_code_q;
  logic       take_first, take_next;

  assign flush_o    = (qs_i == QS_FLUSH);
  assign pop_o      = head_vld_i && (qs_i == QS_FIRST || qs_i == QS_NEXT);
  assign take_first = head_vld_i && (qs_i == QS_FIRST);
  assign take_next  = head_vld_i && (qs_i == QS_NEXT) && in_esc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_esc_q    <= 1'b0;
      op_hi_q     <= '0;
      len_code_q  <= '0;
      dec_vld_o   <= 1'b0;
      dec_op_o    <= '0;
      dec_mod_o   <= '0;
      dec_rm_o    <= '0;
      dec_mem_o   <= 1'b0;
      dec_words_o <= 3'd1;
      dec_store_o <= 1'b0;
    end else begin
      dec_vld_o <= 1'b0;
      if (flush_o) begin
        in_esc_q <= 1'b0;
      end else if (take_first) begin
        in_esc_q   <= (head_i[7:3] == ESC_PATTERN);
        op_hi_q    <= head_i[2:0];
        len_code_q <= head_i[2:1];
      end else if (take_next) begin
        in_esc_q    <= 1'b0;
        dec_vld_o   <= 1'b1;
        dec_op_o    <= {op_hi_q, head_i[5:3]};
        dec_mod_o   <= head_i[7:6];
        dec_rm_o    <= head_i[2:0];
        dec_mem_o   <= (head_i[7:6] != 2'b11);
        dec_words_o <= op_words(len_code_q);
        dec_store_o <= head_i[4];
      end
    end
  end

  assert_dec_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_vld_o |=> !dec_vld_o);
  assert_non_escape_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_first && head_i[7:3] != ESC_PATTERN) |=> !in_esc_q);
  assert_flush_abandons_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !dec_vld_o);
endmodule

// File: rtl/operand_xfer.sv
module operand_xfer
  import cop_snoop_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dec_vld_i,
  input  logic              dec_mem_i,
  input  logic [2:0]        dec_words_i,
  input  logic              dec_store_i,
  input  logic              mem_vld_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_rd_vld_o,
  output logic              bus_req_o,
  output logic              xfer_stb_o,
  output logic              xfer_wr_o,
  output logic [ADDR_W-1:0] xfer_addr_o
);
  xstate_e     st_q;
  logic        store_q;
  logic [2:0]  words_q, left_q, idx_q;

  assign bus_req_o   = (st_q == X_BUS);
  assign xfer_stb_o  = bus_req_o && bus_gnt_i;
  assign xfer_wr_o   = store_q;
  assign xfer_addr_o = op_addr_o + ADDR_W'({idx_q, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= X_IDLE;
      store_q     <= 1'b0;
      words_q     <= 3'd1;
      left_q      <= '0;
      idx_q       <= '0;
      op_addr_o   <= '0;
      op_data_o   <= '0;
      op_rd_vld_o <= 1'b0;
    end else begin
      op_rd_vld_o <= 1'b0;
      case (st_q)
        X_IDLE: if (dec_vld_i && dec_mem_i) begin
          store_q <= dec_store_i;
          words_q <= dec_words_i;
          st_q    <= X_WAIT;
        end
        X_WAIT: if (mem_vld_i) begin
          op_addr_o <= mem_addr_i;
          if (store_q) begin
            idx_q  <= '0;
            left_q <= words_q;
            st_q   <= X_BUS;
          end else begin
            op_data_o   <= mem_data_i;
            op_rd_vld_o <= 1'b1;
            idx_q       <= 3'd1;
            left_q      <= words_q - 1'b1;
            st_q        <= (words_q > 3'd1) ? X_BUS : X_IDLE;
          end
        end
        X_BUS: if (bus_gnt_i) begin
          idx_q  <= idx_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == 3'd1) st_q <= X_IDLE;
        end
        default: st_q <= X_IDLE;
      endcase
    end
  end

  assert_req_drop_after_stb_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_req_o) |-> $past(xfer_stb_o));
  assert_store_no_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_rd_vld_o |-> !store_q);
  assert_reg_form_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == X_IDLE && dec_vld_i && !dec_mem_i) |=> st_q == X_IDLE);
  assert_read_data_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != X_WAIT) |=> $stable(op_data_o));
endmodule

// File: rtl/cop_snoop.sv
module cop_snoop #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int MAX_DEPTH   = 6,
  parameter int SMALL_DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_sel_i,
  input  logic              fetch_vld_i,
  input  logic [7:0]        fetch_byte_i,
  input  logic [1:0]        qs_i,
  input  logic              mem_vld_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic              bus_gnt_i,
  output logic              dec_vld_o,
  output logic [5:0]        dec_op_o,
  output logic [1:0]        dec_mod_o,
  output logic [2:0]        dec_rm_o,
  output logic              dec_mem_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              op_rd_vld_o,
  output logic              bus_req_o,
  output logic              xfer_stb_o,
  output logic              xfer_wr_o,
  output logic [ADDR_W-1:0] xfer_addr_o
);
  logic       sel_done_q, wide_q;
  logic [7:0] head;
  logic       head_vld, pop, flush;
  logic [2:0] dec_words;
  logic       dec_store;

  // strap captured once, in the first cycle out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_done_q <= 1'b0;
      wide_q     <= 1'b0;
    end else if (!sel_done_q) begin
      sel_done_q <= 1'b1;
      wide_q     <= host_sel_i;
    end
  end

  snoop_queue #(.MAX_DEPTH(MAX_DEPTH), .SMALL_DEPTH(SMALL_DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .wide_i     (sel_done_q ? wide_q : host_sel_i),
    .push_i     (fetch_vld_i),
    .push_byte_i(fetch_byte_i),
    .pop_i      (pop),
    .flush_i    (flush),
    .head_o     (head),
    .head_vld_o (head_vld)
  );

  esc_decoder u_dec (
    .clk_i, .rst_ni,
    .qs_i, .head_i(head), .head_vld_i(head_vld),
    .pop_o(pop), .flush_o(flush),
    .dec_vld_o, .dec_op_o, .dec_mod_o, .dec_rm_o, .dec_mem_o,
    .dec_words_o(dec_words), .dec_store_o(dec_store)
  );

  operand_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni,
    .dec_vld_i(dec_vld_o), .dec_mem_i(dec_mem_o),
    .dec_words_i(dec_words), .dec_store_i(dec_store),
    .mem_vld_i, .mem_addr_i, .mem_data_i, .bus_gnt_i,
    .op_addr_o, .op_data_o, .op_rd_vld_o,
    .bus_req_o, .xfer_stb_o, .xfer_wr_o, .xfer_addr_o
  );

  assert_stb_has_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_stb_o |-> bus_req_o);
  assert_reset_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_done_q |-> (!dec_vld_o && !bus_req_o && !op_rd_vld_o));
endmodule

// File: tb/cop_snoop_test.sv
module cop_snoop_test;
  localparam int AW = 20;

  logic          clk_i = 1'b0, rst_ni = 1'b0, host_sel_i = 1'b0;
  logic          fetch_vld_i = 1'b0, mem_vld_i = 1'b0, bus_gnt_i = 1'b0;
  logic [7:0]    fetch_byte_i = '0;
  logic [1:0]    qs_i = 2'b00;
  logic [AW-1:0] mem_addr_i = '0;
  logic [15:0]   mem_data_i = '0;
  logic          dec_vld_o, dec_mem_o, op_rd_vld_o, bus_req_o, xfer_stb_o, xfer_wr_o;
  logic [5:0]    dec_op_o;
  logic [1:0]    dec_mod_o;
  logic [2:0]    dec_rm_o;
  logic [AW-1:0] op_addr_o, xfer_addr_o;
  logic [15:0]   op_data_o;

  int checks = 0, failures = 0, dec_seen = 0;
  bit done = 0;

  cop_snoop uut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
    if (dec_vld_o) dec_seen++;
  endtask

  task automatic do_reset(input logic sel);
    rst_ni = 0; host_sel_i = sel; qs_i = 2'b00; fetch_vld_i = 0;
    mem_vld_i = 0; bus_gnt_i = 0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1;
    cyc();
    host_sel_i = ~sel;
    dec_seen = 0;
  endtask

  task automatic push(input logic [7:0] b);
    fetch_vld_i = 1; fetch_byte_i = b; cyc(); fetch_vld_i = 0;
  endtask

  task automatic q(input logic [1:0] s);
    qs_i = s; cyc(); qs_i = 2'b00;
  endtask

  // push two bytes, pop them; returns after the edge where decode output appears
  task automatic feed_pair(input logic [7:0] b0, input logic [7:0] b1);
    push(b0); push(b1); q(2'b01); q(2'b11);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R10 dec_vld", dec_vld_o, 0);
    chk("R10 bus_req", bus_req_o, 0);
    chk("R10 rd_vld", op_rd_vld_o, 0);
    chk("R10 stb", xfer_stb_o, 0);
  endtask

  task automatic t_non_escape();
    feed_pair(8'h90, 8'h06);
    cyc();
    chk("R3 no decode on non-escape", dec_seen, 0);
  endtask

  task automatic t_flush();
    dec_seen = 0;
    push(8'hD8); push(8'hC1);
    q(2'b01); q(2'b10); q(2'b11); q(2'b01); q(2'b11);
    chk("R2 flush abandons decode", dec_seen, 0);
  endtask

  task automatic t_register_form();
    dec_seen = 0;
    feed_pair(8'hD9, 8'hEA); // mod 11, op lo 101, rm 010
    chk("R4 dec_vld", dec_vld_o, 1);
    chk("R4 dec_op", dec_op_o, 6'b001101);
    chk("R4 dec_mod", dec_mod_o, 2'b11);
    chk("R4 dec_rm", dec_rm_o, 3'b010);
    chk("R5 dec_mem reg", dec_mem_o, 0);
    cyc();
    chk("R4 one-cycle pulse", dec_vld_o, 0);
    mem_vld_i = 1; mem_addr_i = 20'h111; cyc(); mem_vld_i = 0;
    cyc();
    chk("R5 no request reg form", bus_req_o, 0);
    chk("R5 no capture reg form", op_rd_vld_o, 0);
  endtask

  task automatic run_bus(input string req, input int exp_n, input logic [AW-1:0] base,
                         input int off, input logic wr);
    int n = 0;
    bus_gnt_i = 1;
    for (int i = 0; i < 10; i++) begin
      #1;
      if (xfer_stb_o) begin
        chk({req, " addr"}, xfer_addr_o, base + AW'(2 * (off + n)));
        chk({req, " wr"}, xfer_wr_o, wr);
        n++;
      end else if (n > 0) begin
        chk({req, " request dropped after last"}, bus_req_o, 0);
        break;
      end
      @(posedge clk_i); #1;
    end
    bus_gnt_i = 0;
    chk({req, " word count"}, n, exp_n);
  endtask

  task automatic t_read_one();
    feed_pair(8'hD8, 8'h45); // len 1, load, mod 01
    chk("R5 dec_mem", dec_mem_o, 1);
    cyc();
    mem_vld_i = 1; mem_addr_i = 20'h01230; mem_data_i = 16'h5A5A; cyc(); mem_vld_i = 0;
    chk("R7 rd_vld pulse", op_rd_vld_o, 1);
    chk("R7 data", op_data_o, 16'h5A5A);
    chk("R9 one-word load no req", bus_req_o, 0);
    cyc();
    chk("R7 pulse ends", op_rd_vld_o, 0);
  endtask

  task automatic t_read_two();
    feed_pair(8'hDA, 8'h06); // len 2, load
    chk("R4 dec_op load", dec_op_o, 6'b010000);
    cyc();
    mem_vld_i = 1; mem_addr_i = 20'h04000; mem_data_i = 16'hBEEF; cyc(); mem_vld_i = 0;
    chk("R7 addr", op_addr_o, 20'h04000);
    chk("R7 data", op_data_o, 16'hBEEF);
    chk("R9 request up", bus_req_o, 1);
    run_bus("R9 load", 1, 20'h04000, 1, 1'b0);
  endtask

  task automatic t_store_five();
    feed_pair(8'hDE, 8'h93); // len 5, store bit set
    chk("R6 dec_op store", dec_op_o, 6'b110010);
    cyc();
    mem_vld_i = 1; mem_addr_i = 20'h08100; mem_data_i = 16'h1234; cyc(); mem_vld_i = 0;
    chk("R8 addr", op_addr_o, 20'h08100);
    chk("R8 data ignored", op_data_o, 16'hBEEF);
    chk("R8 no rd pulse", op_rd_vld_o, 0);
    run_bus("R6 R9 store", 5, 20'h08100, 0, 1'b1);
  endtask

  task automatic t_depth(input logic sel, input int exp);
    do_reset(sel);
    for (int i = 0; i < 4; i++) push(8'h90);
    push(8'hD8); push(8'hC1);
    for (int i = 0; i < 4; i++) q(2'b01);
    q(2'b01); q(2'b11); cyc();
    chk(sel ? "R1 six-byte queue keeps escape" : "R1 four-byte queue drops overflow",
        dec_seen, exp);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_non_escape();
    t_flush();
    t_register_form();
    t_read_one();
    t_read_two();
    t_store_five();
    t_depth(1'b0, 0);
    t_depth(1'b1, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule